// File: doc/BRIEF.md
# Broadcast Storm Rate Limiter

This block guards one switch ingress port against floods of broadcast traffic. It watches the port's receive strobes: a frame-start pulse with a broadcast flag, a per-byte valid strobe and an end-of-frame strobe. While a time window is open it counts the broadcast data it has let through, in whole 64-byte blocks. When a new broadcast frame starts, the block compares the blocks counted so far with an 11-bit limit. If the count has reached the limit, the frame is refused, and broadcast frames stay refused until the window closes.

The window lasts 67 ms on a 100 Mb/s link and 500 ms on a 10 Mb/s link. A speed-select input chooses between them. Window timing comes from a free-running cycle counter whose limits are derived from a clock-frequency parameter.

The limit is written as two byte registers. Both halves wait in staging registers and move together into the active limit at the next window boundary. The default limit is 99 blocks, about one percent of full-rate minimum-size traffic over a fast window. A saturating count of refused frames can be read through the same register port.

Top module: `bcast_storm_limiter`

## Requirements
- R1: After reset `dec_valid` is 0. The staged and active limit is 0x063. Register reads return 0x00 at address 0, 0x63 at address 1, and 0x00 at addresses 2 and 3.
- R2: A frame whose `rx_bcast` is 0 at its `rx_sof` is always accepted and adds nothing to the block count.
- R3: An accepted broadcast frame of N bytes adds ceil(N/64) blocks. A block is counted on the byte at each offset that is a multiple of 64 from frame start.
- R4: The decision is taken at `rx_sof`. A broadcast frame is accepted when the block count of the current window is below the active limit. Every block of an accepted frame is counted, even past the limit.
- R5: The window lasts CLK_HZ/1000*FAST_MS cycles when `speed_10m` is 0 and CLK_HZ/1000*SLOW_MS cycles when it is 1. The block count is zero for any frame that starts in the last cycle of a window.
- R6: A change on `speed_10m` restarts the window timer. The first boundary after the change falls a full window of the new speed after it.
- R7: The limit is split across two registers. Address 0 bits [2:0] hold limit bits [10:8], and bits [7:3] read as 0. Address 1 bits [7:0] hold limit bits [7:0]. Reads return the staged values.
- R8: A written limit becomes active only at the next window boundary. Frames before that boundary are judged against the old limit.
- R9: An active limit of zero refuses every broadcast frame.
- R10: Each refused frame increments a 16-bit refused-frame counter, which saturates at 0xFFFF. Address 2 reads its low byte and address 3 its high byte.
- R11: `dec_valid` pulses high for one cycle, one cycle after each `rx_sof`. `dec_accept` in that cycle gives the decision (1 = accept).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | Frame start strobe |
| rx_bcast | input | 1 | Frame is broadcast; sampled with rx_sof |
| rx_byte_vld | input | 1 | One frame byte present this cycle |
| rx_eof | input | 1 | Last byte of the frame (with rx_byte_vld) |
| speed_10m | input | 1 | 1 = 10 Mb/s (long window), 0 = 100 Mb/s |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Decision: 1 = accept, 0 = drop |

## Verification
The bench targets the following corner cases, and what a design that got each wrong would do:
- Frames of 64, 65 and 1 bytes. A design that used floor division, or counted whole frames, would let the next broadcast frame through when the limit is reached.
- Broadcast probes two cycles before and exactly at a window boundary, at both speeds, after a speed change. A window of the wrong length, or a timer not restarted by the speed change, moves the accept point.
- A limit written in the middle of a window. Applying it at once would refuse a frame that the old limit still admits.
- A flood of one-cycle frames with a zero limit. A refused-frame counter that wrapped instead of saturating would read back near zero.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
    localparam int THR_W  = 11;
    localparam int DROP_W = 16;
    localparam int BLK_W  = 6;

    typedef enum logic [1:0] {
        ADDR_LIM_HI  = 2'd0,
        ADDR_LIM_LO  = 2'd1,
        ADDR_DROP_LO = 2'd2,
        ADDR_DROP_HI = 2'd3
    } reg_addr_e;

    localparam logic [THR_W-1:0] LIM_RESET = 11'h063;
endpackage

// File: rtl/bsl_window_timer.sv
module bsl_window_timer #(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned FAST_MS = 67,
    parameter int unsigned SLOW_MS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    output logic tick_o
);
    localparam int unsigned LEN_FAST = CLK_HZ / 1000 * FAST_MS;
    localparam int unsigned LEN_SLOW = CLK_HZ / 1000 * SLOW_MS;
    localparam int unsigned LEN_MAX  = (LEN_SLOW > LEN_FAST) ? LEN_SLOW : LEN_FAST;
    localparam int TMR_W = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;
    localparam logic [TMR_W-1:0] END_FAST = TMR_W'(LEN_FAST - 1);
    localparam logic [TMR_W-1:0] END_SLOW = TMR_W'(LEN_SLOW - 1);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic             slow;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    change;
    logic    at_end;

    always_comb begin
        st_d      = st_q;
        change    = (slow_i != st_q.slow);
        at_end    = (st_q.tmr == (slow_i ? END_SLOW : END_FAST));
        st_d.slow = slow_i;
        if (change || at_end) begin
            st_d.tmr = '0;
        end else begin
            st_d.tmr = st_q.tmr + 1'b1;
        end
        tick_o = at_end && !change;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bsl_regfile.sv
module bsl_regfile
    import bsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic              tick_i,
    input  logic              drop_i,
    output logic [THR_W-1:0]  lim_eff_o,
    output logic [THR_W-1:0]  lim_act_o,
    output logic [DROP_W-1:0] drop_cnt_o
);
    localparam int HI_W = THR_W - 8;

    typedef struct packed {
        logic [HI_W-1:0]   stg_hi;
        logic [7:0]        stg_lo;
        logic [THR_W-1:0]  act;
        logic [DROP_W-1:0] drops;
    } reg_st_t;

    reg_st_t          st_d, st_q;
    logic [THR_W-1:0] staged;

    always_comb begin
        st_d   = st_q;
        staged = {st_q.stg_hi, st_q.stg_lo};
        if (we_i) begin
            case (reg_addr_e'(addr_i))
                ADDR_LIM_HI: st_d.stg_hi = wdata_i[HI_W-1:0];
                ADDR_LIM_LO: st_d.stg_lo = wdata_i;
                default: ;
            endcase
        end
        if (tick_i) begin
            st_d.act = staged;
        end
        if (drop_i && (st_q.drops != {DROP_W{1'b1}})) begin
            st_d.drops = st_q.drops + 1'b1;
        end
        lim_eff_o = tick_i ? staged : st_q.act;
        case (reg_addr_e'(addr_i))
            ADDR_LIM_HI:  rdata_o = {{(8-HI_W){1'b0}}, st_q.stg_hi};
            ADDR_LIM_LO:  rdata_o = st_q.stg_lo;
            ADDR_DROP_LO: rdata_o = st_q.drops[7:0];
            default:      rdata_o = st_q.drops[15:8];
        endcase
    end

    assign lim_act_o  = st_q.act;
    assign drop_cnt_o = st_q.drops;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stg_hi <= LIM_RESET[THR_W-1:8];
            st_q.stg_lo <= LIM_RESET[7:0];
            st_q.act    <= LIM_RESET;
            st_q.drops  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bsl_block_meter.sv
module bsl_block_meter
    import bsl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             bcast_i,
    input  logic             byte_vld_i,
    input  logic             eof_i,
    input  logic             tick_i,
    input  logic [THR_W-1:0] lim_eff_i,
    output logic             dec_valid_o,
    output logic             dec_accept_o,
    output logic             drop_o,
    output logic [THR_W-1:0] blk_cnt_o
);
    typedef struct packed {
        logic [THR_W-1:0] cnt;
        logic [BLK_W-1:0] off;
        logic             trk;
        logic             dv;
        logic             da;
    } mtr_st_t;

    mtr_st_t          st_d, st_q;
    logic [THR_W-1:0] base;
    logic [BLK_W-1:0] off_eff;
    logic             accept_now;
    logic             trk_eff;
    logic             inc;

    always_comb begin
        st_d       = st_q;
        base       = tick_i ? '0 : st_q.cnt;
        accept_now = !bcast_i || (base < lim_eff_i);
        trk_eff    = sof_i ? (bcast_i && accept_now) : st_q.trk;
        off_eff    = sof_i ? '0 : st_q.off;
        inc        = byte_vld_i && trk_eff && (off_eff == '0);
        st_d.cnt   = (inc && (base != {THR_W{1'b1}})) ? base + 1'b1 : base;
        st_d.off   = byte_vld_i ? off_eff + 1'b1 : off_eff;
        st_d.trk   = trk_eff && !(eof_i && byte_vld_i);
        st_d.dv    = sof_i;
        st_d.da    = sof_i && accept_now;
        drop_o     = sof_i && !accept_now;
    end

    assign dec_valid_o  = st_q.dv;
    assign dec_accept_o = st_q.da;
    assign blk_cnt_o    = st_q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bcast_storm_limiter.sv
module bcast_storm_limiter
    import bsl_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned FAST_MS = 67,
    parameter int unsigned SLOW_MS = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_sof,
    input  logic       rx_bcast,
    input  logic       rx_byte_vld,
    input  logic       rx_eof,
    input  logic       speed_10m,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       dec_valid,
    output logic       dec_accept
);
    logic              win_tick;
    logic              drop_pulse;
    logic [THR_W-1:0]  lim_eff;
    logic [THR_W-1:0]  thr_act;
    logic [THR_W-1:0]  blk_cnt;
    logic [DROP_W-1:0] drop_cnt;

    bsl_window_timer #(
        .CLK_HZ (CLK_HZ),
        .FAST_MS(FAST_MS),
        .SLOW_MS(SLOW_MS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .slow_i(speed_10m),
        .tick_o(win_tick)
    );

    bsl_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .tick_i    (win_tick),
        .drop_i    (drop_pulse),
        .lim_eff_o (lim_eff),
        .lim_act_o (thr_act),
        .drop_cnt_o(drop_cnt)
    );

    bsl_block_meter u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (rx_sof),
        .bcast_i     (rx_bcast),
        .byte_vld_i  (rx_byte_vld),
        .eof_i       (rx_eof),
        .tick_i      (win_tick),
        .lim_eff_i   (lim_eff),
        .dec_valid_o (dec_valid),
        .dec_accept_o(dec_accept),
        .drop_o      (drop_pulse),
        .blk_cnt_o   (blk_cnt)
    );
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_sof,
    input logic        rx_bcast,
    input logic        dec_valid,
    input logic        dec_accept,
    input logic        win_tick,
    input logic [10:0] thr_act,
    input logic [10:0] blk_cnt,
    input logic [15:0] drop_cnt
);
    p_dec_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sof |=> dec_valid);

    p_dec_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_sof |=> !dec_valid);

    p_nonbcast_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && !rx_bcast) |=> dec_accept);

    p_accept_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && rx_bcast && !win_tick && (blk_cnt < thr_act)) |=> dec_accept);

    p_zero_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && rx_bcast && !win_tick && (thr_act == 11'd0)) |=> !dec_accept);

    p_limit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_tick |=> $stable(thr_act));

    p_window_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_tick |=> (blk_cnt <= 11'd1));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !win_tick |=> ((blk_cnt == $past(blk_cnt)) || (blk_cnt == $past(blk_cnt) + 11'd1)));

    p_drop_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt == 16'hFFFF) |=> (drop_cnt == 16'hFFFF));
endmodule

bind bcast_storm_limiter bsl_checker u_bsl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_sof    (rx_sof),
    .rx_bcast  (rx_bcast),
    .dec_valid (dec_valid),
    .dec_accept(dec_accept),
    .win_tick  (win_tick),
    .thr_act   (thr_act),
    .blk_cnt   (blk_cnt),
    .drop_cnt  (drop_cnt)
);

// File: tb/bcast_storm_limiter_bench.sv
module bcast_storm_limiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 10000;
    localparam int FAST_MS    = 67;
    localparam int SLOW_MS    = 500;
    localparam int LEN_FAST   = CLK_HZ / 1000 * FAST_MS;
    localparam int LEN_SLOW   = CLK_HZ / 1000 * SLOW_MS;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic        bc;
        logic        acc;
        logic [15:0] len;
    } vec_t;

    // limit 4 active, window fresh; blocks: -,1,2,1,drop,-,drop
    localparam vec_t VEC [0:6] = '{
        '{1'b0, 1'b1, 16'd100},
        '{1'b1, 1'b1, 16'd64},
        '{1'b1, 1'b1, 16'd65},
        '{1'b1, 1'b1, 16'd1},
        '{1'b1, 1'b0, 16'd10},
        '{1'b0, 1'b1, 16'd10},
        '{1'b1, 1'b0, 16'd200}
    };

    logic       clk = 0;
    logic       rst_n = 0;
    logic       rx_sof = 0, rx_bcast = 0, rx_byte_vld = 0, rx_eof = 0;
    logic       speed_10m = 0;
    logic       reg_we = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       dec_valid, dec_accept;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int exp_drops = 0;
    int e0 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bcast_storm_limiter #(
        .CLK_HZ(CLK_HZ), .FAST_MS(FAST_MS), .SLOW_MS(SLOW_MS)
    ) u_bcast_storm_limiter (
        .clk(clk), .rst_n(rst_n),
        .rx_sof(rx_sof), .rx_bcast(rx_bcast), .rx_byte_vld(rx_byte_vld), .rx_eof(rx_eof),
        .speed_10m(speed_10m),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic reg_check(logic [1:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic send_frame(bit bc, int len, bit exp_acc, string req);
        @(negedge clk);
        rx_sof = 1; rx_bcast = bc; rx_byte_vld = (len > 0); rx_eof = (len <= 1);
        @(negedge clk);
        rx_sof = 0; rx_bcast = 0;
        check(dec_valid && (dec_accept == exp_acc), req, {dec_valid, dec_accept}, {1'b1, exp_acc});
        if (!exp_acc) exp_drops++;
        for (int i = 1; i < len; i++) begin
            rx_byte_vld = 1; rx_eof = (i == len - 1);
            @(negedge clk);
        end
        rx_byte_vld = 0; rx_eof = 0;
    endtask

    task automatic restart_fast();
        @(negedge clk); speed_10m = 1;
        @(negedge clk); speed_10m = 0;
        e0 = cyc + 1;
    endtask

    task automatic restart_slow();
        @(negedge clk); speed_10m = 1;
        e0 = cyc + 1;
    endtask

    task automatic wait_edge(int n);
        while (cyc < n - 2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        #1 check(dec_valid == 0, "R1 dec_valid", dec_valid, 0);
        reg_check(2'd0, 8'h00, "R1 limit hi");
        reg_check(2'd1, 8'h63, "R1 limit lo");
        reg_check(2'd2, 8'h00, "R1 drops lo");
        reg_check(2'd3, 8'h00, "R1 drops hi");

        // R7 field layout
        reg_write(2'd0, 8'hFD);
        reg_check(2'd0, 8'h05, "R7 hi field masked");
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h04);
        reg_check(2'd1, 8'h04, "R7 lo field");
        reg_check(2'd0, 8'h00, "R7 hi cleared");

        // load limit 4, then fresh window
        repeat (LEN_FAST + 3) @(negedge clk);
        restart_fast();

        // vector table: R2 R3 R4 R11
        for (int k = 0; k < 7; k++) begin
            send_frame(VEC[k].bc, int'(VEC[k].len), VEC[k].acc, "R3/R4 table");
        end
        reg_check(2'd2, 8'(exp_drops), "R10 drop count");

        // R5 count cleared by boundary
        repeat (LEN_FAST + 3) @(negedge clk);
        send_frame(1'b1, 1, 1'b1, "R5 new window accepts");

        // R8 deferred limit
        restart_fast();
        reg_write(2'd1, 8'h00);
        reg_check(2'd1, 8'h00, "R8 staged readback");
        send_frame(1'b1, 1, 1'b1, "R8 old limit still active");
        repeat (LEN_FAST + 3) @(negedge clk);
        send_frame(1'b1, 1, 1'b0, "R9 zero limit drops");
        send_frame(1'b0, 5, 1'b1, "R2 non-broadcast under zero limit");

        // R5 fast window length
        reg_write(2'd1, 8'h01);
        repeat (LEN_FAST + 3) @(negedge clk);
        restart_fast();
        send_frame(1'b1, 1, 1'b1, "R5 first frame of window");
        wait_edge(e0 + LEN_FAST - 2);
        send_frame(1'b1, 1, 1'b0, "R5 fast before boundary");
        send_frame(1'b1, 1, 1'b1, "R5 fast at boundary");

        // R6 slow window after speed change
        restart_slow();
        wait_edge(e0 + LEN_SLOW - 2);
        send_frame(1'b1, 1, 1'b0, "R6 slow before boundary");
        send_frame(1'b1, 1, 1'b1, "R6 slow at boundary");
        reg_check(2'd2, 8'(exp_drops), "R10 drop count lo");

        // R10 saturation with zero limit
        reg_write(2'd1, 8'h00);
        repeat (LEN_SLOW + 3) @(negedge clk);
        @(negedge clk);
        rx_sof = 1; rx_bcast = 1; rx_eof = 1;
        repeat (65540) @(negedge clk);
        rx_sof = 0; rx_bcast = 0; rx_eof = 0;
        @(negedge clk);
        reg_check(2'd2, 8'hFF, "R10 saturated lo");
        reg_check(2'd3, 8'hFF, "R10 saturated hi");

        finish_run();
    end
endmodule